// File: doc/BRIEF.md
# APB I2S Audio Transmitter

This peripheral sits on an APB bus and turns audio samples written by a processor into a serial I2S stream. Software sets an enable bit and a bit-clock divider in a control register. It then writes samples into an eight-entry transmit queue through a data port. The block divides the bus clock down to a serial bit clock. It sends each queued word MSB first, with the left channel first and then the right. It drives a word-select line that changes one bit time before each word begins.

When the queue runs dry, the serializer keeps running and sends silent (all-zero) words. An interrupt register latches events when the queue becomes full and when it becomes empty. Each event has its own enable bit, and the interrupt output is the OR of the enabled events. Software acknowledges an event by writing 1 to its flag.

Top module: `apb_i2s_tx`

## Requirements
- R1: A register write takes effect only in the APB access phase (psel and penable both high). A setup phase without penable changes nothing.
- R2: Offset 0x00 holds the enable in bit 0 and the divider in bits 15:8. A read of 0x00 returns these two fields and zero in every other bit.
- R3: While enabled, bit_clk holds each level for (divider+1) pclk cycles, so a divider of 0 gives pclk/2. While disabled, bit_clk is held low.
- R4: A write to offset 0x04 appends pwdata to a queue that holds 8 words. A write while the queue holds 8 words is dropped.
- R5: A read of 0x04 returns the queue fill level, and a read of any unmapped offset returns zero. prdata is zero whenever there is no read access phase.
- R6: ser_data carries each 32-bit word MSB first, one bit per bit_clk period. It changes only on a falling edge of bit_clk.
- R7: word_sel is 0 for the left word and 1 for the right word, and the first word after enable is a left word. word_sel toggles on the same falling edge of bit_clk that presents a word's LSB, which is one bit time before the next MSB.
- R8: A word that starts while the queue is empty is sent as all zeros. bit_clk and word_sel keep running.
- R9: Offset 0x08 holds the full flag in bit 0, the empty flag in bit 1, the full enable in bit 8 and the empty enable in bit 9. A flag sets in the cycle after the queue becomes full (or becomes empty). Writing 1 to a flag clears it, and a new event in the same cycle wins over the clear.
- R10: irq is high exactly when some flag is set together with its enable bit.
- R11: Clearing the enable returns word_sel and ser_data to 0 and restarts the word at its MSB on the next enable. The queue contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, also the source of the bit clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB peripheral select |
| penable | input | 1 | APB access-phase strobe |
| pwrite | input | 1 | APB direction, 1 for write |
| paddr | input | 32 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq | output | 1 | Interrupt request |
| bit_clk | output | 1 | I2S serial bit clock |
| word_sel | output | 1 | I2S channel select, 0 = left |
| ser_data | output | 1 | I2S serial data |

## Verification
The bench uses the default parameters: 32-bit samples, an 8-word queue and an 8-bit divider. Dividers of 0 and 3 keep an entire stereo frame within 128 to 512 cycles. At these depths the bench can fill the queue, drop a ninth write, drain the queue into silent words and see both interrupt events within a few thousand cycles. Because the divider is small, a disable that lands in the middle of a word is also reachable.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam logic [31:0] OFS_CTRL = 32'h0000_0000;
  localparam logic [31:0] OFS_DATA = 32'h0000_0004;
  localparam logic [31:0] OFS_IRQ  = 32'h0000_0008;

  typedef struct packed {
    logic full_en;
    logic empty_en;
    logic full_flag;
    logic empty_flag;
  } irq_regs_t;
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [LVL_W-1:0] level_nx;
  logic             push_ok, pop_ok;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    level_nx  = level;
    if (push_ok) wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   level_nx = level + 1'b1;
      2'b01:   level_nx = level - 1'b1;
      default: level_nx = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      level  <= level_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             bclk,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt, cnt_nx;
  logic             bclk_nx, wrap;

  assign wrap     = (cnt >= div);
  assign fall_stb = en & wrap & bclk;

  always_comb begin
    cnt_nx  = cnt;
    bclk_nx = bclk;
    if (!en) begin
      cnt_nx  = '0;
      bclk_nx = 1'b0;
    end else if (wrap) begin
      cnt_nx  = '0;
      bclk_nx = ~bclk;
    end else begin
      cnt_nx  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      bclk <= bclk_nx;
    end
  end
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fall_stb,
  input  logic [W-1:0] head,
  input  logic         empty,
  output logic         pop,
  output logic         ws,
  output logic         sd
);
  localparam int BIT_W = $clog2(W);

  logic [BIT_W-1:0] bit_idx, bit_idx_nx;
  logic [W-1:0]     shreg, shreg_nx, word;
  logic             ws_nx, sd_nx, at_msb, at_lsb;

  assign at_msb = (bit_idx == '0);
  assign at_lsb = (bit_idx == BIT_W'(W-1));
  assign pop    = fall_stb & at_msb & ~empty;
  assign word   = empty ? '0 : head;

  always_comb begin
    bit_idx_nx = bit_idx;
    shreg_nx   = shreg;
    ws_nx      = ws;
    sd_nx      = sd;
    if (!en) begin
      bit_idx_nx = '0;
      shreg_nx   = '0;
      ws_nx      = 1'b0;
      sd_nx      = 1'b0;
    end else if (fall_stb) begin
      if (at_msb) begin
        sd_nx    = word[W-1];
        shreg_nx = word << 1;
      end else begin
        sd_nx    = shreg[W-1];
        shreg_nx = shreg << 1;
      end
      if (at_lsb) ws_nx = ~ws;
      bit_idx_nx = at_lsb ? '0 : bit_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      shreg   <= '0;
      ws      <= 1'b0;
      sd      <= 1'b0;
    end else begin
      bit_idx <= bit_idx_nx;
      shreg   <= shreg_nx;
      ws      <= ws_nx;
      sd      <= sd_nx;
    end
  end
endmodule

// File: rtl/apb_i2s_tx.sv
module apb_i2s_tx #(
  parameter int SAMPLE_W = 32,
  parameter int DEPTH    = 8,
  parameter int DIV_W    = 8
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [31:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        irq,
  output logic        bit_clk,
  output logic        word_sel,
  output logic        ser_data
);
  import i2s_tx_pkg::*;

  localparam int LVL_W = $clog2(DEPTH+1);

  logic                access, wr_ctrl, wr_data, wr_irq, rd_acc;
  logic                ctrl_en;
  logic [DIV_W-1:0]    ctrl_div;
  irq_regs_t           irq_q, irq_nx;
  logic                was_full, was_empty;
  logic [LVL_W-1:0]    fifo_level;
  logic                fifo_full, fifo_empty, fifo_pop, fall_stb;
  logic [SAMPLE_W-1:0] fifo_head;

  assign access  = psel & penable;
  assign wr_ctrl = access & pwrite & (paddr == OFS_CTRL);
  assign wr_data = access & pwrite & (paddr == OFS_DATA);
  assign wr_irq  = access & pwrite & (paddr == OFS_IRQ);
  assign rd_acc  = access & ~pwrite;

  always_comb begin
    irq_nx = irq_q;
    if (wr_irq) begin
      irq_nx.full_en  = pwdata[8];
      irq_nx.empty_en = pwdata[9];
    end
    irq_nx.full_flag  = (irq_q.full_flag  & ~(wr_irq & pwdata[0])) | (fifo_full  & ~was_full);
    irq_nx.empty_flag = (irq_q.empty_flag & ~(wr_irq & pwdata[1])) | (fifo_empty & ~was_empty);
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_en   <= 1'b0;
      ctrl_div  <= '0;
      irq_q     <= '0;
      was_full  <= 1'b0;
      was_empty <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= pwdata[0];
        ctrl_div <= pwdata[8 +: DIV_W];
      end
      irq_q     <= irq_nx;
      was_full  <= fifo_full;
      was_empty <= fifo_empty;
    end
  end

  assign irq = (irq_q.full_flag & irq_q.full_en) | (irq_q.empty_flag & irq_q.empty_en);

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      case (paddr)
        OFS_CTRL: prdata = 32'({ctrl_div, 7'b0, ctrl_en});
        OFS_DATA: prdata = 32'(fifo_level);
        OFS_IRQ:  prdata = {22'b0, irq_q.empty_en, irq_q.full_en, 6'b0,
                            irq_q.empty_flag, irq_q.full_flag};
        default:  prdata = '0;
      endcase
    end
  end

  i2s_tx_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (pclk),
    .rst_n     (presetn),
    .push      (wr_data),
    .push_data (pwdata[SAMPLE_W-1:0]),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  i2s_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk      (pclk),
    .rst_n    (presetn),
    .en       (ctrl_en),
    .div      (ctrl_div),
    .bclk     (bit_clk),
    .fall_stb (fall_stb)
  );

  i2s_tx_shift #(.W(SAMPLE_W)) u_shift (
    .clk      (pclk),
    .rst_n    (presetn),
    .en       (ctrl_en),
    .fall_stb (fall_stb),
    .head     (fifo_head),
    .empty    (fifo_empty),
    .pop      (fifo_pop),
    .ws       (word_sel),
    .sd       (ser_data)
  );
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             pclk,
  input logic             presetn,
  input logic             psel,
  input logic             penable,
  input logic             bit_clk,
  input logic             word_sel,
  input logic             ser_data,
  input logic             ctrl_en,
  input logic [LVL_W-1:0] level,
  input logic             full_flag
);
  // R1
  ctrl_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable) |=> $stable(ctrl_en));

  // R3
  bclk_idle_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !ctrl_en |=> !bit_clk);

  // R6
  sd_edge_chk: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(ctrl_en) && !$stable(ser_data)) |-> $fell(bit_clk));

  // R7
  ws_edge_chk: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(ctrl_en) && !$stable(word_sel)) |-> $fell(bit_clk));

  // R4
  level_cap_chk: assert property (@(posedge pclk) disable iff (!presetn)
    32'(level) <= DEPTH);

  // R9
  full_flag_src_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(full_flag) |-> (32'($past(level)) == DEPTH));
endmodule

bind apb_i2s_tx i2s_tx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .pclk      (pclk),
  .presetn   (presetn),
  .psel      (psel),
  .penable   (penable),
  .bit_clk   (bit_clk),
  .word_sel  (word_sel),
  .ser_data  (ser_data),
  .ctrl_en   (ctrl_en),
  .level     (fifo_level),
  .full_flag (irq_q.full_flag)
);

// File: tb/apb_i2s_tx_tb.sv
module apb_i2s_tx_tb;
  localparam int DEPTH = 8;

  logic        pclk, presetn, psel, penable, pwrite;
  logic [31:0] paddr, pwdata, prdata;
  logic        irq, bit_clk, word_sel, ser_data;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  bit cmp_on = 0;

  apb_i2s_tx u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq(irq), .bit_clk(bit_clk), .word_sel(word_sel), .ser_data(ser_data)
  );

  initial pclk = 0;
  always #10 pclk = ~pclk;

  // reference model state
  bit          m_en, m_bclk, m_ws, m_sd;
  int          m_div, m_cnt, m_bit;
  logic [31:0] m_sh;
  logic [31:0] q[$];
  bit          m_ff, m_ef, m_fe, m_ee, m_wasfull, m_wasempty;

  always @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      m_en = 0; m_bclk = 0; m_ws = 0; m_sd = 0; m_div = 0; m_cnt = 0; m_bit = 0;
      m_sh = 0; q.delete(); m_ff = 0; m_ef = 0; m_fe = 0; m_ee = 0;
      m_wasfull = 0; m_wasempty = 1;
    end else begin
      bit wr, fall, pop, push, n_ff, n_ef;
      int lvl;
      logic [31:0] word;
      wr   = psel && penable && pwrite;
      lvl  = q.size();
      fall = m_en && (m_cnt >= m_div) && m_bclk;
      pop  = fall && (m_bit == 0) && (lvl != 0);
      push = wr && (paddr == 32'h4) && (lvl < DEPTH);
      n_ff = (m_ff && !(wr && paddr == 32'h8 && pwdata[0])) || (lvl == DEPTH && !m_wasfull);
      n_ef = (m_ef && !(wr && paddr == 32'h8 && pwdata[1])) || (lvl == 0 && !m_wasempty);
      m_ff = n_ff; m_ef = n_ef;
      m_wasfull = (lvl == DEPTH); m_wasempty = (lvl == 0);
      if (wr && paddr == 32'h8) begin m_fe = pwdata[8]; m_ee = pwdata[9]; end
      if (!m_en) begin
        m_bit = 0; m_ws = 0; m_sd = 0; m_sh = 0;
      end else if (fall) begin
        if (m_bit == 0) begin
          word = (lvl != 0) ? q[0] : 32'h0;
          m_sd = word[31]; m_sh = word << 1;
        end else begin
          m_sd = m_sh[31]; m_sh = m_sh << 1;
        end
        if (m_bit == 31) m_ws = ~m_ws;
        m_bit = (m_bit + 1) % 32;
      end
      if (pop) void'(q.pop_front());
      if (push) q.push_back(pwdata);
      if (!m_en) begin m_cnt = 0; m_bclk = 0; end
      else if (m_cnt >= m_div) begin m_cnt = 0; m_bclk = ~m_bclk; end
      else m_cnt = m_cnt + 1;
      if (wr && paddr == 32'h0) begin m_en = pwdata[0]; m_div = int'(pwdata[15:8]); end
    end
  end

  function automatic logic [31:0] exp_rdata();
    if (!(psel && penable && !pwrite)) return 32'h0;
    case (paddr)
      32'h0:   return (32'(m_div) << 8) | 32'(m_en);
      32'h4:   return 32'(q.size());
      32'h8:   return {22'b0, m_ee, m_fe, 6'b0, m_ef, m_ff};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge pclk) begin
    if (cmp_on && presetn) begin
      chk("R3 bit_clk",  32'(bit_clk),  32'(m_bclk));
      chk("R7 word_sel", 32'(word_sel), 32'(m_ws));
      chk("R6 ser_data", 32'(ser_data), 32'(m_sd));
      chk("R10 irq",     32'(irq),      32'(m_ff & m_fe | m_ef & m_ee));
      chk("R5 prdata",   prdata,        exp_rdata());
    end
  end

  task automatic apb_wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge pclk); #2;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge pclk); #2; penable = 1;
    @(posedge pclk); #2; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(posedge pclk); #2;
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge pclk); #2; penable = 1;
    @(negedge pclk); chk(tag, prdata, exp);
    @(posedge pclk); #2; psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge pclk);
    #2;
  endtask

  function automatic logic [31:0] pattern(input int i);
    return 32'h8000_0001 ^ (32'(i) * 32'h1357_9BDF);
  endfunction

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    presetn = 0;
    repeat (3) @(posedge pclk);
    #2 presetn = 1;
    @(negedge pclk);
    // reset state
    chk("R3 reset bit_clk", 32'(bit_clk), 0);
    chk("R7 reset word_sel", 32'(word_sel), 0);
    chk("R6 reset ser_data", 32'(ser_data), 0);
    chk("R10 reset irq", 32'(irq), 0);
    cmp_on = 1;

    // R1: setup phase alone must not write
    @(posedge pclk); #2;
    psel = 1; penable = 0; pwrite = 1; paddr = 32'h0; pwdata = 32'h0000_0301;
    @(posedge pclk); #2; psel = 0; pwrite = 0;
    apb_rd(32'h0, 32'h0, "R1 setup-only write ignored");
    idle(4);
    chk("R1 bit_clk still idle", 32'(bit_clk), 0);

    // R9 enables
    apb_wr(32'h8, 32'h0000_0300);
    apb_rd(32'h8, 32'h0000_0300, "R9 enable bits readback");

    // R4: fill queue, ninth write dropped
    for (int i = 0; i < DEPTH + 1; i++) apb_wr(32'h4, pattern(i));
    apb_rd(32'h4, 32'd8, "R4 level capped at depth");
    apb_rd(32'h8, 32'h0000_0301, "R9 full flag set");
    chk("R10 irq on full", 32'(irq), 1);
    apb_wr(32'h8, 32'h0000_0301);
    apb_rd(32'h8, 32'h0000_0300, "R9 full flag cleared by write-1");
    chk("R10 irq drops after clear", 32'(irq), 0);

    // R5 unmapped
    apb_rd(32'h0000_000C, 32'h0, "R5 unmapped read zero");
    apb_rd(32'h0001_0000, 32'h0, "R5 high unmapped read zero");

    // R2: enable with divider 0, upper garbage dropped
    apb_wr(32'h0, 32'hABCD_0001);
    apb_rd(32'h0, 32'h0000_0001, "R2 control readback");
    idle(8 * 64 + 40);
    apb_rd(32'h4, 32'd0, "R4 queue drained");
    apb_rd(32'h8, 32'h0000_0302, "R9 empty flag set");
    chk("R10 irq on empty", 32'(irq), 1);

    // R8: silent words while empty, clock still running
    begin
      int ones = 0, edges = 0;
      logic last = bit_clk;
      for (int c = 0; c < 140; c++) begin
        @(negedge pclk);
        if (ser_data) ones++;
        if (bit_clk != last) edges++;
        last = bit_clk;
      end
      chk("R8 zeros when empty", 32'(ones), 0);
      chk("R8 bit_clk keeps toggling", 32'(edges > 100), 1);
    end

    // R3/R6 slower divider with fresh words
    apb_wr(32'h8, 32'h0000_0303);
    apb_wr(32'h0, 32'h0000_0300);
    apb_wr(32'h0, 32'h0000_0301);
    apb_rd(32'h0, 32'h0000_0301, "R2 divider readback");
    for (int i = 0; i < 3; i++) apb_wr(32'h4, pattern(20 + i));
    idle(300);

    // R11: disable in mid-word
    apb_wr(32'h0, 32'h0000_0300);
    idle(3);
    @(negedge pclk);
    chk("R11 word_sel low after disable", 32'(word_sel), 0);
    chk("R11 ser_data low after disable", 32'(ser_data), 0);
    chk("R3 bit_clk low when disabled", 32'(bit_clk), 0);
    apb_wr(32'h0, 32'h0000_0001);
    idle(400);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule